// File: doc/BRIEF.md
# Packed-Lane Integer Media Execution Unit

This unit is one execution slice of a vector pipeline. It takes 128-bit operands and treats them either as sixteen independent 8-bit lanes or as four independent 32-bit lanes. The operation depends on a small opcode. The byte-lane operations suit motion search and interpolation in video work. One gives the unsigned distance between two bytes. The other gives their mean, rounded upward.

The word-lane operations come as a pair for multi-precision addition. One returns the carry-out of a 32-bit sum as a whole word. The other adds two words plus the low bit of the destination word. That destination word arrives on a third operand input. Feeding the carry words of one step into the destination input of the next step extends an addition to any width, across lanes and across instructions.

Each accepted operation produces a registered result and a valid flag on the following clock. Codes outside the defined set give a zeroed result and raise an error flag alongside the valid flag.

Top module: `vec_media_alu`

## Requirements
- R1: With `in_op` = 0, every byte lane k (bits 8k+7..8k) of `out_result` is the unsigned magnitude of the difference between the matching bytes of `src_a` and `src_b`.
- R2: With `in_op` = 1, every byte lane is (a + b + 1) >> 1, computed at 9 bits, so 0xFF and 0xFF give 0xFF.
- R3: With `in_op` = 2, every 32-bit word lane (bits 32j+31..32j) holds the carry-out of a + b in bit 0, and bits 31..1 of the lane are zero. For example, 0xFFFFFFFF + 1 gives 1.
- R4: With `in_op` = 3, every word lane is (a + b + t[0]) mod 2^32, where t is the matching word of `src_t`. Bits 31..1 of t have no effect on the result.
- R5: `in_op` values 0 to 3 are the only legal codes, and each gives `out_err` = 0. Codes 4 to 7 give an all-zero `out_result` with `out_err` = 1.
- R6: `out_valid` is high in exactly the cycle after a clock edge that samples `in_valid` high. The result of that operation is present in that cycle.
- R7: A synchronous active-high `rst` clears `out_valid`, `out_err` and `out_result` to zero at the next edge.
- R8: After an edge that samples `in_valid` low, `out_result` keeps its previous value, and `out_valid` and `out_err` are low.
- R9: No carry or borrow crosses a lane boundary. A word-lane overflow in any operation, including the add-with-carry of R4, is discarded and leaves the neighbouring lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (0 abs-diff, 1 average, 2 carry-out, 3 add-with-carry) |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| src_t | input | 128 | Destination operand (carry-in source for code 3) |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 128 | Registered result |
| out_err | output | 1 | Illegal code flag, qualified by out_valid |

## Verification
Any fault in a lane datapath or in the opcode select shows up as a wrong lane value on the very next cycle after the strobe. Each lane is compared on its own, so a fault is pinned to the lane and operation that caused it. A fault in the capture-enable or reset logic shows one cycle later as a result that changes while idle, or as a flag that stays high without a strobe. Boundary operands target the ninth bit of the average, the carry out of an all-ones word, the add-with-carry carry-in and overflow at lane edges. These expose any truncation or carry leak on the first operation that uses them.

// File: rtl/vma_pkg.sv
package vma_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_ABSDB = 3'd0;
  localparam logic [OP_W-1:0] OP_AVGB  = 3'd1;
  localparam logic [OP_W-1:0] OP_CGEN  = 3'd2;
  localparam logic [OP_W-1:0] OP_ADDX  = 3'd3;
endpackage

// File: rtl/vma_byte_unit.sv
module vma_byte_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] absd,
  output logic [W-1:0] avg
);
  logic [W:0] rsum;
  logic       a_ge_b;

  always_comb begin
    rsum   = {1'b0, a} + {1'b0, b} + (W+1)'(1);
    avg    = rsum[W:1];
    a_ge_b = (a >= b);
    absd   = a_ge_b ? (a - b) : (b - a);
  end
endmodule

// File: rtl/vma_word_unit.sv
module vma_word_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] cgen,
  output logic [W-1:0] addx
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    cgen = {{(W-1){1'b0}}, wide[W]};
    addx = wide[W-1:0] + W'(cin);
  end
endmodule

// File: rtl/vma_out_stage.sv
module vma_out_stage #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d_result,
  input  logic          d_err,
  output logic          q_valid,
  output logic [DW-1:0] q_result,
  output logic          q_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_err    <= 1'b0;
      q_result <= '0;
    end else begin
      q_valid <= load;
      q_err   <= load & d_err;
      if (load) q_result <= d_result;
    end
  end
endmodule

// File: rtl/vec_media_alu.sv
module vec_media_alu #(
  parameter int DATA_W = 128,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [vma_pkg::OP_W-1:0] in_op,
  input  logic [DATA_W-1:0]        src_a,
  input  logic [DATA_W-1:0]        src_b,
  input  logic [DATA_W-1:0]        src_t,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_result,
  output logic                     out_err
);
  import vma_pkg::*;

  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int N_WORDS = DATA_W / WORD_W;

  logic [DATA_W-1:0] absd_v, avg_v, cgen_v, addx_v;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_err;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    vma_byte_unit #(.W(BYTE_W)) u_byte (
      .a    (src_a[i*BYTE_W +: BYTE_W]),
      .b    (src_b[i*BYTE_W +: BYTE_W]),
      .absd (absd_v[i*BYTE_W +: BYTE_W]),
      .avg  (avg_v[i*BYTE_W +: BYTE_W])
    );
  end

  for (genvar j = 0; j < N_WORDS; j++) begin : g_word
    vma_word_unit #(.W(WORD_W)) u_word (
      .a    (src_a[j*WORD_W +: WORD_W]),
      .b    (src_b[j*WORD_W +: WORD_W]),
      .cin  (src_t[j*WORD_W]),
      .cgen (cgen_v[j*WORD_W +: WORD_W]),
      .addx (addx_v[j*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    nxt_err = 1'b0;
    case (in_op)
      OP_ABSDB: nxt_result = absd_v;
      OP_AVGB:  nxt_result = avg_v;
      OP_CGEN:  nxt_result = cgen_v;
      OP_ADDX:  nxt_result = addx_v;
      default: begin
        nxt_result = '0;
        nxt_err    = 1'b1;
      end
    endcase
  end

  vma_out_stage #(.DW(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (in_valid),
    .d_result (nxt_result),
    .d_err    (nxt_err),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_err    (out_err)
  );
endmodule

// File: rtl/vma_checker.sv
module vma_checker #(
  parameter int DATA_W = 128,
  parameter int WORD_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [vma_pkg::OP_W-1:0] in_op,
  input logic [DATA_W-1:0]        src_a,
  input logic [DATA_W-1:0]        src_b,
  input logic [DATA_W-1:0]        src_t,
  input logic                     out_valid,
  input logic [DATA_W-1:0]        out_result,
  input logic                     out_err
);
  localparam int N_WORDS = DATA_W / WORD_W;

  function automatic logic [DATA_W-1:0] upper_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_WORDS; k++) m[k*WORD_W+1 +: WORD_W-1] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CG_HI = upper_mask();

  assert_strobe_latency_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_err));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  assert_err_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && out_result == '0));
  assert_legal_no_err_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op < 3'd4) |=> !out_err);
  assert_cgen_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd2) |=> ((out_result & CG_HI) == '0));
  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_result == '0));

  for (genvar j = 0; j < N_WORDS; j++) begin : g_addx
    assert_addx_lane_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == 3'd3) |=>
        out_result[j*WORD_W +: WORD_W] ==
          $past(src_a[j*WORD_W +: WORD_W] + src_b[j*WORD_W +: WORD_W]
                + WORD_W'(src_t[j*WORD_W])));
  end
endmodule

bind vec_media_alu vma_checker #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .src_a(src_a), .src_b(src_b), .src_t(src_t),
  .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
);

// File: tb/vec_media_alu_tb.sv
`timescale 1ns/1ps
module vec_media_alu_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [127:0] src_a = '0, src_b = '0, src_t = '0;
  logic         out_valid, out_err;
  logic [127:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  vec_media_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .src_a(src_a), .src_b(src_b), .src_t(src_t),
    .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
  );

  function automatic logic [127:0] model(input logic [2:0] op,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] t);
    logic [127:0] r;
    r = '0;
    case (op)
      3'd0, 3'd1:
        for (int i = 0; i < 16; i++) begin
          int x, y;
          x = int'(a[8*i +: 8]);
          y = int'(b[8*i +: 8]);
          if (op == 3'd0) r[8*i +: 8] = 8'((x > y) ? x - y : y - x);
          else            r[8*i +: 8] = 8'((x + y + 1) / 2);
        end
      3'd2, 3'd3:
        for (int j = 0; j < 4; j++) begin
          longint s;
          s = longint'({32'd0, a[32*j +: 32]}) + longint'({32'd0, b[32*j +: 32]});
          if (op == 3'd2) r[32*j +: 32] = 32'(s >> 32);
          else            r[32*j +: 32] = 32'(s + longint'(t[32*j]));
        end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, return after its result has been registered.
  task automatic issue(input logic [2:0] op, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; src_a = a; src_b = b; src_t = t;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] t);
    issue(op, a, b, t);
    check({req, " valid"}, {127'd0, out_valid}, 128'd1);
    check({req, " err"},   {127'd0, out_err},   {127'd0, (op > 3'd3)});
    check({req, " data"},  out_result, model(op, a, b, t));
  endtask

  task automatic t_reset_R7();
    issue(3'd3, {4{32'h1234_5678}}, {4{32'h1111_1111}}, '0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R7 valid", {127'd0, out_valid}, '0);
    check("R7 err",   {127'd0, out_err},   '0);
    check("R7 data",  out_result, '0);
  endtask

  task automatic t_absdb_R1();
    run_op("R1 mixed", 3'd0, 128'h00FF_10_20_80_7F_01_FE_55_AA_00_00_C3_3C_99_01,
                             128'hFF00_20_10_7F_80_FE_01_AA_55_00_FF_3C_C3_01_99, '0);
    run_op("R1 equal", 3'd0, {16{8'h5A}}, {16{8'h5A}}, '0);
  endtask

  task automatic t_avgb_R2();
    run_op("R2 ninth bit", 3'd1, {16{8'hFF}}, {16{8'hFF}}, '0);
    check("R2 ff+ff", out_result, {16{8'hFF}});
    run_op("R2 round up", 3'd1, {8{8'h01, 8'h00}}, {8{8'h02, 8'h00}}, '0);
  endtask

  task automatic t_cgen_R3();
    run_op("R3 corner", 3'd2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, '0);
    check("R3 ones+1", out_result, {4{32'h0000_0001}});
    run_op("R3 no carry", 3'd2, {4{32'h7FFF_FFFF}}, {4{32'h8000_0000}}, '0);
  endtask

  task automatic t_addx_R4();
    run_op("R4 cin1", 3'd3, {4{32'h0000_0010}}, {4{32'h0000_0020}}, {4{32'h0000_0001}});
    check("R4 sum", out_result, {4{32'h0000_0031}});
    // upper destination bits set with bit 0 clear: must act as carry-in 0
    run_op("R4 upper ignored", 3'd3, {4{32'h0000_0010}}, {4{32'h0000_0020}}, {4{32'hFFFF_FFFE}});
    check("R4 sum no cin", out_result, {4{32'h0000_0030}});
  endtask

  task automatic t_isolation_R9();
    run_op("R9 addx wrap", 3'd3, {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF},
                                 {96'h0, 32'h0}, {96'h0, 32'h1});
    check("R9 addx lanes", out_result, 128'h0);
    run_op("R9 byte edge", 3'd1, {8'h00, 8'hFF, 112'h0}, {8'h00, 8'hFF, 112'h0}, '0);
    check("R9 avg lanes", out_result, {8'h00, 8'hFF, 112'h0});
  endtask

  task automatic t_illegal_R5();
    for (int c = 4; c < 8; c++) begin
      run_op("R5 illegal", 3'(c), {16{8'hA5}}, {16{8'h3C}}, {4{32'h1}});
      check("R5 zero", out_result, '0);
      check("R5 flag", {127'd0, out_err}, 128'd1);
    end
  endtask

  task automatic t_hold_R8_R6();
    logic [127:0] kept;
    run_op("R6 load", 3'd0, {16{8'h40}}, {16{8'h10}}, '0);
    kept = out_result;
    @(negedge clk);
    src_a = '1; src_b = '0; in_op = 3'd1;
    @(negedge clk);
    check("R8 hold data", out_result, kept);
    check("R8 no valid", {127'd0, out_valid}, '0);
    check("R8 no err", {127'd0, out_err}, '0);
    run_op("R8 illegal then idle", 3'd7, '0, '0, '0);
    @(negedge clk);
    check("R8 err cleared", {127'd0, out_err}, '0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [127:0] a, b, t;
      logic [2:0] op;
      a  = {$urandom, $urandom, $urandom, $urandom};
      b  = {$urandom, $urandom, $urandom, $urandom};
      t  = {$urandom, $urandom, $urandom, $urandom};
      op = 3'($urandom_range(0, 3));
      issue(op, a, b, t);
      check("R1 R2 R3 R4 random", out_result, model(op, a, b, t));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 initial valid", {127'd0, out_valid}, '0);
    check("R7 initial data", out_result, '0);
    t_absdb_R1();
    t_avgb_R2();
    t_cgen_R3();
    t_addx_R4();
    t_isolation_R9();
    t_illegal_R5();
    t_hold_R8_R6();
    t_reset_R7();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule